// File: doc/BRIEF.md
# CRC-16 Polynomial Field Multiplier

This block multiplies two 16-bit values as polynomials over GF(2) and reduces the result modulo the CRC-16 generator x^16 + x^12 + x^5 + 1. Software-style CRC engines use this operation to fold a partial CRC forward by a number of zero bytes, or to combine byte contributions that arrive in reverse order. In those uses one operand is a padding multiplier of the form x^(8n) mod P and the other is a byte or a CRC value.

The datapath is fully combinational between an input strobe and one output register stage. It first forms the 31-bit carryless product. The reduction does not use long division. The upper fifteen product bits are multiplied by a fixed reciprocal of the generator, and that product is shifted to give the quotient. The quotient times the generator is then cancelled out of the low sixteen product bits. The reciprocal is computed at elaboration from the generator.

A request is a single-cycle strobe with both operands. The reduced result appears on the registered output one clock later, together with a one-cycle valid pulse. Requests may arrive on every cycle.

Top module: `crc_gfmul_top`

## Requirements
- R1: For any operands A and B, the result equals the bit-serial reference. That reference starts from zero and runs 16 steps, taking B from bit 15 down to bit 0. Each step shifts the accumulator left by one and XORs 0x1021 when the bit that leaves is 1, then XORs A when the current B bit is 1.
- R2: Multiplying by one returns the other operand unchanged: B = 0x0001 gives A, and A = 0x0001 gives B.
- R3: If either operand is zero, the result is 0x0000.
- R4: The result does not change when A and B are swapped.
- R5: Reduction wraps the degree-16 term to 0x1021. So 0x0100 times 0x0100 gives 0x1021, and 0x8000 times 0x0002 gives 0x1021.
- R6: A request sampled with in_vld high at a rising edge produces out_vld high for exactly the following cycle, with out_res holding that request's result. Requests on consecutive cycles each produce their own result on consecutive cycles.
- R7: While in_vld is low, out_vld stays low and out_res keeps its last value, whatever op_a and op_b do.
- R8: While rst_n is low, out_vld is 0 and out_res is 0x0000. Release is synchronised, so a request is ignored until the second rising edge after rst_n goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| in_vld | input | 1 | Request strobe, one request per high cycle |
| op_a | input | 16 | First polynomial operand |
| op_b | input | 16 | Second polynomial operand |
| out_vld | output | 1 | One-cycle pulse marking a new result |
| out_res | output | 16 | Registered (op_a x op_b) mod P |

## Verification
The clocked properties assume that op_a and op_b are valid, not X, on every cycle where in_vld is high. They also assume that nothing is relied on until the internal synchronised reset has released. The bench meets both assumptions. It drives the operands and the strobe only on falling edges, always gives the operands a defined value, and waits out the release delay before it issues a request. It also drives in_vld high during reset and during the release window, so the assertions are exercised only through the reset-qualified path.

// File: rtl/crc_gfmul_pkg.sv
package crc_gfmul_pkg;

  // Operand and result width (degree of the generator).
  localparam int unsigned GW = 16;
  // Width of the full carryless product.
  localparam int unsigned PROD_W = 2 * GW - 1;
  // Width of the part of the product above the result field.
  localparam int unsigned HI_W = PROD_W - GW;
  // Width of the reciprocal product hi * recip.
  localparam int unsigned RP_W = HI_W + GW - 1;
  // Low terms of the generator; the x^GW term is implicit.
  localparam logic [GW-1:0] GEN_LO = 16'h1021;
  localparam logic [GW:0]   GEN_FULL = {1'b1, GEN_LO};

  // floor(x^(2*GW-1) / generator), found by borrowless long division.
  function automatic logic [GW-1:0] calc_recip();
    logic [GW:0]   num;
    logic [GW-1:0] quo;
    num = '0;
    num[GW] = 1'b1;
    quo = '0;
    for (int i = 0; i < GW; i++) begin
      quo = {quo[GW-2:0], num[GW]};
      if (num[GW]) num = num ^ GEN_FULL;
      num = {num[GW-1:0], 1'b0};
    end
    return quo;
  endfunction

  localparam logic [GW-1:0] RECIP = calc_recip();

endpackage

// File: rtl/crc_gfmul_clmul.sv
// Carryless multiplier: each product column is the XOR of the operand bit
// pairs whose indices sum to that column. The XOR reduction is left to
// synthesis as a balanced 2-input tree.
module crc_gfmul_clmul #(
  parameter int unsigned AW = 16,
  parameter int unsigned BW = 16,
  localparam int unsigned PW = AW + BW - 1
) (
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [PW-1:0] p_o
);

  for (genvar k = 0; k < PW; k++) begin : g_col
    logic [AW-1:0] terms;
    for (genvar i = 0; i < AW; i++) begin : g_row
      if ((k - i) >= 0 && (k - i) < BW) begin : g_on
        assign terms[i] = a_i[i] & b_i[k-i];
      end else begin : g_off
        assign terms[i] = 1'b0;
      end
    end
    assign p_o[k] = ^terms;
  end

endmodule

// File: rtl/crc_gfmul_reduce.sv
// Reciprocal-based reduction of a full carryless product modulo the generator.
module crc_gfmul_reduce
  import crc_gfmul_pkg::*;
(
  input  logic [PROD_W-1:0] prod_i,
  output logic [GW-1:0]     rem_o
);

  logic [HI_W-1:0]           hi;
  logic [RP_W-1:0]           rp;
  logic [HI_W-1:0]           quo;
  logic [HI_W+GW-2:0]        qg;
  logic                      unused_bits;

  assign hi = prod_i[PROD_W-1:GW];

  // quotient = (hi * recip) >> (GW-1)
  crc_gfmul_clmul #(.AW(HI_W), .BW(GW)) u_recip_mul (
    .a_i (hi),
    .b_i (RECIP),
    .p_o (rp)
  );

  assign quo = rp[RP_W-1:GW-1];

  // Only the low GW bits of quo*generator matter; the x^GW term of the
  // generator lands at or above bit GW and is dropped.
  crc_gfmul_clmul #(.AW(HI_W), .BW(GW)) u_gen_mul (
    .a_i (quo),
    .b_i (GEN_LO),
    .p_o (qg)
  );

  assign rem_o = prod_i[GW-1:0] ^ qg[GW-1:0];

  assign unused_bits = ^{rp[GW-2:0], qg[HI_W+GW-2:GW]};

endmodule

// File: rtl/crc_gfmul_top.sv
module crc_gfmul_top
  import crc_gfmul_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [GW-1:0] op_a,
  input  logic [GW-1:0] op_b,
  output logic          out_vld,
  output logic [GW-1:0] out_res
);

  // Reset release synchroniser.
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_q = rst_sync_q[1];

  // Datapath.
  logic [PROD_W-1:0] prod;
  logic [GW-1:0]     rem;

  crc_gfmul_clmul #(.AW(GW), .BW(GW)) u_prod_mul (
    .a_i (op_a),
    .b_i (op_b),
    .p_o (prod)
  );

  crc_gfmul_reduce u_reduce (
    .prod_i (prod),
    .rem_o  (rem)
  );

  // Next state.
  logic          vld_d, vld_q;
  logic          res_en;
  logic [GW-1:0] res_d, res_q;

  always_comb begin
    vld_d  = in_vld;
    res_en = in_vld;
    res_d  = rem;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign out_vld = vld_q;
  assign out_res = res_q;

  // Bit-serial model used only by the checks below.
  function automatic logic [GW-1:0] serial_mul(logic [GW-1:0] a, logic [GW-1:0] b);
    logic [GW-1:0] acc;
    acc = '0;
    for (int i = GW - 1; i >= 0; i--) begin
      acc = {acc[GW-2:0], 1'b0} ^ (acc[GW-1] ? GEN_LO : '0);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  // R1: registered result matches the serial model of the captured operands
  assert_serial_match_R1: assert property (@(posedge clk) disable iff (!rst_q)
    in_vld |=> (out_res == serial_mul($past(op_a), $past(op_b))));

  // R2: unit operand passes the other through
  assert_unit_pass_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (in_vld && op_b == 16'h0001) |=> (out_res == $past(op_a)));

  // R3: zero operand yields zero
  assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (in_vld && (op_a == '0 || op_b == '0)) |=> (out_res == '0));

  // R6: each accepted request gives a valid pulse on the next cycle
  assert_vld_follow_R6: assert property (@(posedge clk) disable iff (!rst_q)
    in_vld |=> out_vld);

  // R7: no request, no pulse, result held
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_q)
    !in_vld |=> (!out_vld && $stable(out_res)));

endmodule

// File: tb/crc_gfmul_top_tb_top.sv
module crc_gfmul_top_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        in_vld;
  logic [15:0] op_a;
  logic [15:0] op_b;
  logic        out_vld;
  logic [15:0] out_res;

  int n_checks;
  int n_fails;
  logic [31:0] lfsr;

  crc_gfmul_top dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .op_a    (op_a),
    .op_b    (op_b),
    .out_vld (out_vld),
    .out_res (out_res)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Independent model: shift-and-XOR over B from its top bit.
  function automatic logic [15:0] model_mul(logic [15:0] a, logic [15:0] b);
    logic [15:0] pd;
    pd = 16'h0000;
    for (int i = 0; i < 16; i++) begin
      if (pd[15]) pd = {pd[14:0], 1'b0} ^ 16'h1021;
      else        pd = {pd[14:0], 1'b0};
      if (b[15 - i]) pd = pd ^ a;
    end
    return pd;
  endfunction

  function automatic logic [31:0] next_rand(logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one request and check the cycle after.
  task automatic issue_check(string req, logic [15:0] a, logic [15:0] b, logic [15:0] exp);
    @(negedge clk);
    in_vld = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    in_vld = 1'b0;
    check(req, {31'd0, out_vld}, 32'd1);
    check(req, {16'd0, out_res}, {16'd0, exp});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_vld = 1'b1; op_a = 16'h1234; op_b = 16'h5678;
    repeat (3) @(negedge clk);
    check("R8 reset vld", {31'd0, out_vld}, 32'd0);
    check("R8 reset res", {16'd0, out_res}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // one edge after release: still held in reset
    check("R8 release vld", {31'd0, out_vld}, 32'd0);
    check("R8 release res", {16'd0, out_res}, 32'd0);
    in_vld = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 settled vld", {31'd0, out_vld}, 32'd0);
  endtask

  task automatic t_wrap();
    issue_check("R5 x8*x8", 16'h0100, 16'h0100, 16'h1021);
    issue_check("R5 x15*x", 16'h8000, 16'h0002, 16'h1021);
    issue_check("R1 ffff*ffff", 16'hFFFF, 16'hFFFF, model_mul(16'hFFFF, 16'hFFFF));
  endtask

  task automatic t_unit();
    issue_check("R2 a*1", 16'hBEEF, 16'h0001, 16'hBEEF);
    issue_check("R2 1*b", 16'h0001, 16'hC0DE, 16'hC0DE);
  endtask

  task automatic t_zero();
    issue_check("R3 a*0", 16'hA5A5, 16'h0000, 16'h0000);
    issue_check("R3 0*b", 16'h0000, 16'hFFFF, 16'h0000);
  endtask

  task automatic t_commute();
    for (int j = 0; j < 6; j++) begin
      logic [15:0] a, b, exp;
      lfsr = next_rand(lfsr); a = lfsr[15:0]; b = lfsr[31:16];
      exp = model_mul(a, b);
      issue_check("R4 a*b", a, b, exp);
      issue_check("R4 b*a", b, a, exp);
    end
  endtask

  task automatic t_random();
    for (int j = 0; j < 200; j++) begin
      logic [15:0] a, b;
      lfsr = next_rand(lfsr); a = lfsr[15:0]; b = lfsr[31:16];
      issue_check("R1 random", a, b, model_mul(a, b));
    end
  endtask

  task automatic t_stream();
    logic [15:0] prev;
    for (int j = 0; j < 10; j++) begin
      logic [15:0] a, b;
      lfsr = next_rand(lfsr); a = lfsr[15:0]; b = lfsr[31:16];
      @(negedge clk);
      if (j > 0) begin
        check("R6 stream vld", {31'd0, out_vld}, 32'd1);
        check("R6 stream res", {16'd0, out_res}, {16'd0, prev});
      end
      in_vld = 1'b1; op_a = a; op_b = b;
      prev = model_mul(a, b);
    end
    @(negedge clk);
    in_vld = 1'b0;
    check("R6 stream last", {16'd0, out_res}, {16'd0, prev});
    @(negedge clk);
    check("R6 single pulse", {31'd0, out_vld}, 32'd0);
  endtask

  task automatic t_hold();
    logic [15:0] exp;
    exp = model_mul(16'h1357, 16'h2468);
    issue_check("R7 load", 16'h1357, 16'h2468, exp);
    for (int j = 0; j < 4; j++) begin
      op_a = 16'hFFFF - 16'(j); op_b = 16'h8000 >> j;
      @(negedge clk);
      check("R7 idle vld", {31'd0, out_vld}, 32'd0);
      check("R7 idle res", {16'd0, out_res}, {16'd0, exp});
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    n_checks = 0;
    n_fails  = 0;
    lfsr     = 32'h1D2C3B4A;
    t_reset();
    t_wrap();
    t_unit();
    t_zero();
    t_commute();
    t_stream();
    t_hold();
    t_random();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule